// File: doc/BRIEF.md
# Clock Source Run-Request Controller

This block sits beside an on-chip frequency-locked oscillator and decides when it runs. Software writes a 16-bit control word over a simple single-cycle write port. The word reads back on the cycle after the write. Its effect on the oscillator reaches the rest of the block only after a fixed synchronizer delay. A ready flag stays low while that delay runs, and any write presented during it is dropped. A write-protect input blocks writes without starting that delay.

The run decision combines four things: the applied enable bit, an on-request mode, a keep-in-standby option and the standby sleep state. In on-request mode the oscillator runs only while a peripheral asks for it.

The block keeps sticky coarse and fine lock flags. It can hold the output-valid signal low until fine lock is reached. When the oscillator was stopped during sleep, the lock flags can optionally be discarded on wake.

Top module: `clksrc_run_ctrl`

## Requirements
- R1: After reset the read value is 0x0080 (on-request set, all else clear), ready is high, and the oscillator, output-valid and both lock flags are low.
- R2: An accepted write reads back on the next cycle, with bit 0 and bits 15..12 forced to zero.
- R3: After an accepted write, ready is low for exactly 3 cycles. The written word takes effect on the oscillator run decision and on `cfg_o` in the cycle in which ready returns high.
- R4: A write presented while ready is low is ignored.
- R5: A write presented while `wr_prot_i` is high is ignored, and ready stays high.
- R6: With bit 7 (on-request) clear and not in standby, the oscillator runs exactly when bit 1 (enable) is set.
- R7: With bits 1 and 7 both set, the oscillator runs exactly when at least one bit of `periph_req_i` is high, in both active and standby states.
- R8: With bit 1 set, bit 7 clear and standby high, the oscillator runs only on a peripheral request when bit 6 (keep-in-standby) is clear, and always when bit 6 is set.
- R9: With bit 11 (hold-for-lock) set, output-valid is high only while the oscillator runs and the fine lock flag is set. With bit 11 clear, output-valid equals the oscillator run state.
- R10: A lock flag is set by its set pulse only while the oscillator runs, and it stays set otherwise.
- R11: With bit 4 (drop-lock-on-wake) set, both lock flags clear on the cycle that standby falls if the oscillator was stopped during that standby period. Otherwise the flags are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control-word write strobe |
| wr_prot_i | input | 1 | Write protect, blocks writes |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Control word read value |
| sync_ready_o | output | 1 | High when no synchronization is pending |
| cfg_o | output | 16 | Applied (synchronized) control word |
| periph_req_i | input | NREQ | Peripheral clock requests |
| standby_i | input | 1 | Standby sleep state |
| coarse_set_i | input | 1 | Coarse lock reached pulse |
| fine_set_i | input | 1 | Fine lock reached pulse |
| osc_run_o | output | 1 | Oscillator run command |
| clk_valid_o | output | 1 | Output clock may be used |
| coarse_lock_o | output | 1 | Coarse lock flag |
| fine_lock_o | output | 1 | Fine lock flag |

## Verification
The bench sweeps every combination of enable, on-request, keep-in-standby, standby and all sixteen request patterns. This catches a design that drops standby retention or lets on-request mode leak into the enabled state. It looks for the exact cycle in which ready returns and the run state changes. A one-off synchronizer count would move that edge or apply the word early. It writes during busy and under protection, which catches a design that queues writes or that starts a busy period on a protected write. It covers three cases of lock loss on wake: stopped during sleep, kept running, and option off. A design that clears the flags on every wake, or never clears them, fails one of these.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;
  localparam int CW = 16;
  // bit positions of the control word
  localparam int B_EN         = 1;
  localparam int B_LOOP_CLOSE = 2;
  localparam int B_FREEZE     = 3;
  localparam int B_DROP_WAKE  = 4;
  localparam int B_USB_REC    = 5;
  localparam int B_KEEP_STBY  = 6;
  localparam int B_ON_REQ     = 7;
  localparam int B_NO_CHILL   = 8;
  localparam int B_NO_QUICK   = 9;
  localparam int B_SKIP_COARS = 10;
  localparam int B_HOLD_LOCK  = 11;
  localparam logic [CW-1:0] CTRL_RST   = 16'h0080;
  localparam logic [CW-1:0] CTRL_WMASK = 16'h0FFE;
endpackage

// File: rtl/clksrc_ctrl_reg.sv
module clksrc_ctrl_reg
  import clksrc_pkg::*;
#(
  parameter int SYNC_LAT = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_prot_i,
  input  logic [CW-1:0] wr_data_i,
  output logic [CW-1:0] rd_data_o,
  output logic          ready_o,
  output logic [CW-1:0] applied_o
);
  localparam int CNTW = $clog2(SYNC_LAT + 1);
  localparam logic [CNTW-1:0] LAT = CNTW'(SYNC_LAT);

  logic [CNTW-1:0] cnt_q;
  logic [CW-1:0]   ctrl_q, applied_q;
  logic            wr_acc;

  assign ready_o = (cnt_q == '0);
  assign wr_acc  = wr_en_i & ~wr_prot_i & ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      ctrl_q    <= CTRL_RST;
      applied_q <= CTRL_RST;
    end else if (wr_acc) begin
      ctrl_q <= wr_data_i & CTRL_WMASK;
      cnt_q  <= LAT;
    end else if (!ready_o) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNTW'(1)) applied_q <= ctrl_q;
    end
  end

  assign rd_data_o = ctrl_q;
  assign applied_o = applied_q;

  a_r3_busy_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_prot_i && ready_o) |=> !ready_o);
  a_r4_busy_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !ready_o) |=> $stable(rd_data_o));
  a_r5_prot_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_prot_i && ready_o) |=> ($stable(rd_data_o) && ready_o));
  a_r3_applied_only_on_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(applied_o) |-> ready_o);
endmodule

// File: rtl/clksrc_run_decide.sv
module clksrc_run_decide #(
  parameter int NREQ = 4
) (
  input  logic            en_i,
  input  logic            on_req_i,
  input  logic            keep_stby_i,
  input  logic            standby_i,
  input  logic [NREQ-1:0] req_i,
  output logic            run_o
);
  logic any_req;
  assign any_req = |req_i;

  always_comb begin
    if (!en_i)                        run_o = 1'b0;
    else if (on_req_i)                run_o = any_req;
    else if (standby_i && !keep_stby_i) run_o = any_req;
    else                              run_o = 1'b1;
  end
endmodule

// File: rtl/clksrc_lock_gate.sv
module clksrc_lock_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic standby_i,
  input  logic coarse_set_i,
  input  logic fine_set_i,
  input  logic drop_on_wake_i,
  input  logic hold_for_lock_i,
  output logic coarse_o,
  output logic fine_o,
  output logic valid_o
);
  logic stby_q, slept_stop_q, coarse_q, fine_q;
  logic wake, drop;

  assign wake = stby_q & ~standby_i;
  assign drop = wake & drop_on_wake_i & slept_stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stby_q       <= 1'b0;
      slept_stop_q <= 1'b0;
      coarse_q     <= 1'b0;
      fine_q       <= 1'b0;
    end else begin
      stby_q <= standby_i;
      if (wake)                    slept_stop_q <= 1'b0;
      else if (standby_i && !run_i) slept_stop_q <= 1'b1;
      if (drop) begin
        coarse_q <= 1'b0;
        fine_q   <= 1'b0;
      end else begin
        if (coarse_set_i && run_i) coarse_q <= 1'b1;
        if (fine_set_i && run_i)   fine_q   <= 1'b1;
      end
    end
  end

  assign coarse_o = coarse_q;
  assign fine_o   = fine_q;
  assign valid_o  = run_i & (~hold_for_lock_i | fine_q);

  a_r11_drop_on_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake && drop_on_wake_i && slept_stop_q) |=> (!coarse_o && !fine_o));
  a_r10_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wake) |=> ($stable(coarse_o) && $stable(fine_o)));
  a_r11_keep_without_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drop_on_wake_i && fine_o) |=> fine_o);
endmodule

// File: rtl/clksrc_run_ctrl.sv
module clksrc_run_ctrl
  import clksrc_pkg::*;
#(
  parameter int NREQ     = 4,
  parameter int SYNC_LAT = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            wr_prot_i,
  input  logic [CW-1:0]   wr_data_i,
  output logic [CW-1:0]   rd_data_o,
  output logic            sync_ready_o,
  output logic [CW-1:0]   cfg_o,
  input  logic [NREQ-1:0] periph_req_i,
  input  logic            standby_i,
  input  logic            coarse_set_i,
  input  logic            fine_set_i,
  output logic            osc_run_o,
  output logic            clk_valid_o,
  output logic            coarse_lock_o,
  output logic            fine_lock_o
);
  logic [CW-1:0] applied;

  clksrc_ctrl_reg #(.SYNC_LAT(SYNC_LAT)) u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_prot_i, .wr_data_i,
    .rd_data_o, .ready_o(sync_ready_o), .applied_o(applied)
  );

  clksrc_run_decide #(.NREQ(NREQ)) u_run (
    .en_i(applied[B_EN]), .on_req_i(applied[B_ON_REQ]),
    .keep_stby_i(applied[B_KEEP_STBY]), .standby_i,
    .req_i(periph_req_i), .run_o(osc_run_o)
  );

  clksrc_lock_gate u_lock (
    .clk_i, .rst_ni, .run_i(osc_run_o), .standby_i,
    .coarse_set_i, .fine_set_i,
    .drop_on_wake_i(applied[B_DROP_WAKE]), .hold_for_lock_i(applied[B_HOLD_LOCK]),
    .coarse_o(coarse_lock_o), .fine_o(fine_lock_o), .valid_o(clk_valid_o)
  );

  assign cfg_o = applied;

  a_r6_off_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_o[B_EN] |-> !osc_run_o);
  a_r7_no_request_no_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o[B_ON_REQ] && periph_req_i == '0) |-> !osc_run_o);
  a_r9_valid_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_valid_o |-> osc_run_o);
  a_r9_valid_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o[B_HOLD_LOCK] && !fine_lock_o) |-> !clk_valid_o);
endmodule

// File: tb/tb_clksrc_run_ctrl.sv
module tb_clksrc_run_ctrl;
  localparam int NREQ = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_prot = 0, standby = 0, cset = 0, fset = 0;
  logic [15:0] wr_data = '0;
  logic [NREQ-1:0] req = '0;
  logic [15:0] rd_data, cfg;
  logic ready, run, valid, clock_c, clock_f;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clksrc_run_ctrl #(.NREQ(NREQ), .SYNC_LAT(3)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_prot_i(wr_prot),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .sync_ready_o(ready), .cfg_o(cfg),
    .periph_req_i(req), .standby_i(standby), .coarse_set_i(cset), .fine_set_i(fset),
    .osc_run_o(run), .clk_valid_o(valid), .coarse_lock_o(clock_c), .fine_lock_o(clock_f)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // presents a write for one edge; returns at the negedge after it
  task automatic wr(input logic [15:0] d, input logic prot);
    @(negedge clk); wr_en = 1; wr_data = d; wr_prot = prot;
    @(negedge clk); wr_en = 0; wr_prot = 0;
  endtask

  task automatic wr_sync(input logic [15:0] d);
    wr(d, 1'b0);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_locks;
    @(negedge clk); cset = 1; fset = 1;
    @(negedge clk); cset = 0; fset = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rd", rd_data, 16'h0080);
    chk("R1 ready", ready, 1);
    chk("R1 run/valid/locks", {run, valid, clock_c, clock_f}, 0);

    // R2 / R3: write full word, watch ready and apply timing
    wr(16'hFFFF, 1'b0);
    chk("R2 readback masked", rd_data, 16'h0FFE);
    chk("R3 ready low c1", ready, 0);
    chk("R3 not yet applied", {cfg, run}, {16'h0080, 1'b0});
    @(negedge clk); chk("R3 ready low c2", ready, 0);
    @(negedge clk); chk("R3 ready low c3", ready, 0);
    chk("R3 still not applied", cfg, 16'h0080);
    @(negedge clk); chk("R3 ready back", ready, 1);
    chk("R3 applied", cfg, 16'h0FFE);

    // R4: write while busy dropped
    wr(16'h0002, 1'b0);
    wr(16'h0080, 1'b0);
    repeat (3) @(negedge clk);
    chk("R4 busy write ignored", rd_data, 16'h0002);
    chk("R4 applied first only", {cfg, run}, {16'h0002, 1'b1});

    // R5: protected write
    wr(16'h0FFE, 1'b1);
    chk("R5 prot ready stays", ready, 1);
    chk("R5 prot ignored", rd_data, 16'h0002);
    chk("R5 run unchanged", run, 1);

    // R6/R7/R8 sweep
    for (int c = 0; c < 8; c++) begin
      logic en, od, ks;
      en = c[0]; od = c[1]; ks = c[2];
      wr_sync({8'h00, od, ks, 4'h0, en, 1'b0});
      for (int s = 0; s < 2; s++) begin
        for (int r = 0; r < 16; r++) begin
          logic any, exp;
          @(negedge clk); standby = s[0]; req = r[NREQ-1:0];
          #1;
          any = (r != 0);
          exp = en && (od ? any : ((s != 0) && !ks) ? any : 1'b1);
          if (od)           chk("R7 on-request run", run, exp);
          else if (s != 0)  chk("R8 standby run", run, exp);
          else              chk("R6 enable run", run, exp);
        end
      end
    end
    @(negedge clk); standby = 0; req = 0;

    // R9: hold for lock (flags still clear)
    wr_sync(16'h0802);
    chk("R9 held before lock", {run, valid}, 2'b10);
    pulse_locks();
    chk("R10 set while running", {clock_c, clock_f}, 2'b11);
    chk("R9 valid after lock", valid, 1);
    wr_sync(16'h0002);
    chk("R9 no hold valid=run", valid, 1);
    wr_sync(16'h0000);
    chk("R9 stopped invalid", {run, valid}, 2'b00);
    chk("R10 kept while idle", {clock_c, clock_f}, 2'b11);

    // R11: drop on wake, stopped in sleep
    wr_sync(16'h0092);
    @(negedge clk); req = 4'h1; standby = 1;
    @(negedge clk); req = 4'h0;
    @(negedge clk); #1 chk("R7 stopped in standby", run, 0);
    @(negedge clk); standby = 0; req = 4'h1;
    @(negedge clk); chk("R11 dropped on wake", {clock_c, clock_f}, 2'b00);
    // R10: pulse while stopped does not set
    req = 4'h0;
    pulse_locks();
    chk("R10 no set while stopped", {clock_c, clock_f}, 2'b00);
    // R11: running through sleep keeps flags
    @(negedge clk); req = 4'h2;
    pulse_locks();
    @(negedge clk); standby = 1;
    repeat (2) @(negedge clk);
    standby = 0;
    @(negedge clk); chk("R11 kept when running in sleep", {clock_c, clock_f}, 2'b11);
    // R11: option off, stopped in sleep keeps flags
    wr_sync(16'h0082);
    @(negedge clk); req = 0; standby = 1;
    repeat (2) @(negedge clk);
    standby = 0;
    @(negedge clk); chk("R11 kept with option off", {clock_c, clock_f}, 2'b11);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule